// File: doc/BRIEF.md
# Byte-Register Serial Port (8N1)

This block is a small asynchronous serial port that sits on a byte-wide register bus whose registers are spaced four bytes apart. It sends and receives characters of eight data bits, least significant bit first, with no parity and a single stop bit. The transmit side has a single holding slot. The receive side fills a four-entry FIFO that software empties by reading the data register again and again until the "receive empty" flag returns.

A 16-bit divisor, split across a low and a high byte register, sets a tick that runs at four times the bit rate. For a clock `F` and a rate `B`, software programs `F/(4*B) - 1`. A single status/control register combines three kinds of bit. Two are interrupt enables that software can write. Four are live FIFO and transmitter flags. Two are sticky error flags, and software clears them by writing a 0 to their bit position. One interrupt output serves both directions.

Top module: `byte_uart`

## Requirements
- R1: After reset, irq is 0 and serial output is 1. STATUS (offset 20) reads 0xA0: TX-empty bit 7 is 1, RX-empty bit 5 is 1, and both enables and both error bits are 0.
- R2: Offsets 0, 4, 8 and 12 return bytes 0, 1, 2 and 3 of the ID_VALUE parameter. Unmapped offsets read 0.
- R3: The divisor low byte sits at offset 24 and the high byte at offset 28. Both read back what was written. One serial bit lasts 4*(divisor+1) clocks.
- R4: A write to DATA (offset 16) while TX-empty is 1 sends a frame: a start bit at 0, eight data bits LSB first, then a stop bit at 1. Each bit lasts four ticks. TX-empty is 0 while the frame is in flight and returns to 1 after the stop bit.
- R5: A DATA write while TX-empty is 0 is ignored: the frame in flight is unchanged and no further frame follows.
- R6: The receiver sees a falling edge on the line at a tick and confirms it is low two ticks later. It then samples each data bit at mid-bit, four ticks apart, LSB first, and stores the character in the RX FIFO.
- R7: The RX FIFO is first-in first-out with four entries, and each DATA read pops one entry. STATUS bit 5 is 1 when the FIFO is empty, bit 4 is 1 when exactly one free slot is left, and bit 3 is 1 when it is full.
- R8: When a character completes while the FIFO is full, the character is discarded, the stored entries are kept, and overrun (bit 1) is set.
- R9: When the stop bit is sampled low, frame error (bit 0) is set. The character is still stored.
- R10: Both error bits are sticky. A STATUS write with the bit at 0 clears it, and a write with the bit at 1 leaves it unchanged. The RX enable (bit 2) and TX enable (bit 6) take the written value. Writes to bits 3, 4, 5 and 7 are ignored.
- R11: irq = (bit 2 AND (FIFO not empty OR any error bit set)) OR (bit 6 AND TX-empty).
- R12: A DATA read while the FIFO is empty returns the last character read and leaves the FIFO unchanged.
- R13: A low pulse that is no longer high-to-low-confirmed two ticks after detection stores nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Byte address of the register |
| reg_wr_en | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rd_en | input | 1 | Read strobe; a read of DATA pops the FIFO at the clock edge |
| reg_rdata | output | 8 | Read data, valid in the same cycle as reg_rd_en |
| ser_rx | input | 1 | Serial input, idle high |
| ser_tx | output | 1 | Serial output, idle high |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that read and write strobes are never asserted together. They also assume that the serial input holds each bit for a full four-tick bit time, and that the divisor does not change while a frame is in flight. The stimulus changes the divisor only when both directions are idle. Received frames are driven at exactly the programmed bit time from a clean, idle-high line. The only deliberately short pulse on the line is the glitch case.

// File: rtl/byte_uart_pkg.sv
package byte_uart_pkg;
   localparam int OFF_ID0   = 0;
   localparam int OFF_ID1   = 4;
   localparam int OFF_ID2   = 8;
   localparam int OFF_ID3   = 12;
   localparam int OFF_DATA  = 16;
   localparam int OFF_STAT  = 20;
   localparam int OFF_DIVLO = 24;
   localparam int OFF_DIVHI = 28;

   localparam int ST_FERR  = 0;
   localparam int ST_OERR  = 1;
   localparam int ST_RXIE  = 2;
   localparam int ST_FULL  = 3;
   localparam int ST_ONE   = 4;
   localparam int ST_EMPTY = 5;
   localparam int ST_TXIE  = 6;
   localparam int ST_TXE   = 7;

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
endpackage

// File: rtl/byte_uart_baud.sv
module byte_uart_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = (cnt >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end

   assert_tick_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (cnt == '0));
endmodule

// File: rtl/byte_uart_tx.sv
module byte_uart_tx #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              load,
   input  logic [DATA_W-1:0] data,
   output logic              txd,
   output logic              busy
);
   localparam int FRAME_W = DATA_W + 2;
   localparam int IDX_W   = $clog2(FRAME_W);

   logic [FRAME_W-1:0] shreg;
   logic [IDX_W-1:0]   idx;
   logic [1:0]         sub;

   assign txd = shreg[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '1;
         idx   <= '0;
         sub   <= '0;
         busy  <= 1'b0;
      end else if (load && !busy) begin
         shreg <= {1'b1, data, 1'b0};
         idx   <= '0;
         sub   <= '0;
         busy  <= 1'b1;
      end else if (busy && tick) begin
         if (sub == 2'd3) begin
            sub <= '0;
            if (idx == IDX_W'(FRAME_W - 1)) begin
               busy <= 1'b0;
            end else begin
               idx   <= idx + 1'b1;
               shreg <= {1'b1, shreg[FRAME_W-1:1]};
            end
         end else begin
            sub <= sub + 1'b1;
         end
      end
   end

   assert_tx_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !busy) |=> (busy && !txd));
   assert_tx_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (load && busy && !tick) |=> $stable(shreg));
   assert_tx_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> txd);
endmodule

// File: rtl/byte_uart_rx.sv
module byte_uart_rx #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rxd,
   output logic              done,
   output logic              stop_ok,
   output logic [DATA_W-1:0] data
);
   import byte_uart_pkg::*;

   localparam int BIT_W = $clog2(DATA_W);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("byte_uart_rx: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync;
   logic                   line, line_prev;
   rx_state_t              st;
   logic [1:0]             cnt;
   logic [BIT_W-1:0]       nbit;

   assign line = sync[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync <= '1;
      else        sync <= {sync[SYNC_STAGES-2:0], rxd};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= RX_IDLE;
         cnt       <= '0;
         nbit      <= '0;
         data      <= '0;
         done      <= 1'b0;
         stop_ok   <= 1'b1;
         line_prev <= 1'b1;
      end else begin
         done <= 1'b0;
         if (tick) begin
            line_prev <= line;
            case (st)
               RX_IDLE: if (line_prev && !line) begin
                  st  <= RX_START;
                  cnt <= '0;
               end
               RX_START: if (cnt == 2'd1) begin
                  cnt  <= '0;
                  nbit <= '0;
                  st   <= line ? RX_IDLE : RX_DATA;
               end else begin
                  cnt <= cnt + 1'b1;
               end
               RX_DATA: if (cnt == 2'd3) begin
                  cnt  <= '0;
                  data <= {line, data[DATA_W-1:1]};
                  if (nbit == BIT_W'(DATA_W - 1)) st <= RX_STOP;
                  else                            nbit <= nbit + 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
               default: if (cnt == 2'd3) begin
                  cnt     <= '0;
                  done    <= 1'b1;
                  stop_ok <= line;
                  st      <= RX_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            endcase
         end
      end
   end

   assert_rx_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_rx_from_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (st == RX_IDLE && $past(st) == RX_STOP));
   assert_rx_glitch_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RX_START && tick && cnt == 2'd1 && line) |=> (st == RX_IDLE && !done));
endmodule

// File: rtl/byte_uart_fifo.sv
module byte_uart_fifo #(
   parameter int DEPTH  = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   input  logic              pop,
   output logic [DATA_W-1:0] dout,
   output logic              full,
   output logic              one_left,
   output logic              empty
);
   localparam int PTR_W = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("byte_uart_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W:0]    wptr, rptr, count;
   logic [DATA_W-1:0] last;
   logic              do_push, do_pop;

   assign count    = wptr - rptr;
   assign empty    = (count == '0);
   assign full     = (count == (PTR_W+1)'(DEPTH));
   assign one_left = (count == (PTR_W+1)'(DEPTH - 1));
   assign do_push  = push && !full;
   assign do_pop   = pop && !empty;
   assign dout     = empty ? last : mem[rptr[PTR_W-1:0]];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr[PTR_W-1:0]] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         last <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop) begin
            rptr <= rptr + 1'b1;
            last <= mem[rptr[PTR_W-1:0]];
         end
      end
   end

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (full && $stable(wptr)));
   assert_empty_pop_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> (empty && $stable(rptr) && $stable(dout)));
   assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      count <= (PTR_W+1)'(DEPTH));
endmodule

// File: rtl/byte_uart.sv
module byte_uart #(
   parameter int          ADDR_W      = 5,
   parameter int          DIV_W       = 16,
   parameter int          RX_DEPTH    = 4,
   parameter int          SYNC_STAGES = 2,
   parameter logic [31:0] ID_VALUE    = 32'h5A01C37E,
   parameter logic [15:0] DIV_RESET   = 16'd1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr_en,
   input  logic [7:0]        reg_wdata,
   input  logic              reg_rd_en,
   output logic [7:0]        reg_rdata,
   input  logic              ser_rx,
   output logic              ser_tx,
   output logic              irq
);
   import byte_uart_pkg::*;

   localparam int DATA_W = 8;

   generate
      if (DIV_W != 16) begin : g_bad_div
         $error("byte_uart: divisor must span exactly two byte registers");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("byte_uart: ADDR_W too small for the register map");
      end
   endgenerate

   logic [DIV_W-1:0]  div;
   logic              tick, tx_busy, tx_load;
   logic              rx_done, rx_stop_ok;
   logic [DATA_W-1:0] rx_char, fifo_dout;
   logic              f_full, f_one, f_empty, f_pop;
   logic              rx_ie, tx_ie, ferr, oerr;
   logic              wr_stat, wr_data;
   logic [7:0]        status;

   assign wr_stat = reg_wr_en && (reg_addr == ADDR_W'(OFF_STAT));
   assign wr_data = reg_wr_en && (reg_addr == ADDR_W'(OFF_DATA));
   assign tx_load = wr_data && !tx_busy;
   assign f_pop   = reg_rd_en && (reg_addr == ADDR_W'(OFF_DATA));

   byte_uart_baud #(.DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .div(div), .tick(tick));

   byte_uart_tx #(.DATA_W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(tx_load),
      .data(reg_wdata), .txd(ser_tx), .busy(tx_busy));

   byte_uart_rx #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(ser_rx),
      .done(rx_done), .stop_ok(rx_stop_ok), .data(rx_char));

   byte_uart_fifo #(.DEPTH(RX_DEPTH), .DATA_W(DATA_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(rx_done), .din(rx_char),
      .pop(f_pop), .dout(fifo_dout), .full(f_full), .one_left(f_one),
      .empty(f_empty));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div   <= DIV_RESET;
         rx_ie <= 1'b0;
         tx_ie <= 1'b0;
         ferr  <= 1'b0;
         oerr  <= 1'b0;
      end else begin
         if (reg_wr_en && reg_addr == ADDR_W'(OFF_DIVLO)) div[7:0]  <= reg_wdata;
         if (reg_wr_en && reg_addr == ADDR_W'(OFF_DIVHI)) div[15:8] <= reg_wdata;
         if (wr_stat) begin
            rx_ie <= reg_wdata[ST_RXIE];
            tx_ie <= reg_wdata[ST_TXIE];
         end
         ferr <= (ferr && !(wr_stat && !reg_wdata[ST_FERR])) || (rx_done && !rx_stop_ok);
         oerr <= (oerr && !(wr_stat && !reg_wdata[ST_OERR])) || (rx_done && f_full);
      end
   end

   always_comb begin
      status           = '0;
      status[ST_FERR]  = ferr;
      status[ST_OERR]  = oerr;
      status[ST_RXIE]  = rx_ie;
      status[ST_FULL]  = f_full;
      status[ST_ONE]   = f_one;
      status[ST_EMPTY] = f_empty;
      status[ST_TXIE]  = tx_ie;
      status[ST_TXE]   = !tx_busy;
   end

   always_comb begin
      case (reg_addr)
         ADDR_W'(OFF_ID0):   reg_rdata = ID_VALUE[7:0];
         ADDR_W'(OFF_ID1):   reg_rdata = ID_VALUE[15:8];
         ADDR_W'(OFF_ID2):   reg_rdata = ID_VALUE[23:16];
         ADDR_W'(OFF_ID3):   reg_rdata = ID_VALUE[31:24];
         ADDR_W'(OFF_DATA):  reg_rdata = fifo_dout;
         ADDR_W'(OFF_STAT):  reg_rdata = status;
         ADDR_W'(OFF_DIVLO): reg_rdata = div[7:0];
         ADDR_W'(OFF_DIVHI): reg_rdata = div[15:8];
         default:            reg_rdata = '0;
      endcase
   end

   assign irq = (rx_ie && (!f_empty || ferr || oerr)) || (tx_ie && !tx_busy);

   assert_ferr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ferr && !wr_stat) |=> ferr);
   assert_oerr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (oerr && !(wr_stat && !reg_wdata[ST_OERR])) |=> oerr);
   assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && f_full) |=> oerr);
   assert_irq_tx_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && reg_wdata[ST_TXIE] && !tx_busy && !tx_load) |=> irq);
   assert_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_en && reg_rd_en));
endmodule

// File: tb/byte_uart_tb.sv
module byte_uart_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] reg_addr = '0;
   logic       reg_wr_en = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic       reg_rd_en = 1'b0;
   logic [7:0] reg_rdata;
   logic       ser_rx = 1'b1;
   logic       ser_tx;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   localparam logic [31:0] IDV = 32'h5A01C37E;

   always #4 clk = ~clk;

   byte_uart #(.ID_VALUE(IDV)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
      .reg_wdata(reg_wdata), .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata),
      .ser_rx(ser_rx), .ser_tx(ser_tx), .irq(irq));

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = 5'(a); reg_wdata = d; reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = 5'(a); reg_rd_en = 1'b1;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd_en = 1'b0;
   endtask

   // bit time with divisor 1: 4 ticks * 2 clocks
   task automatic send_rx(input logic [7:0] b, input logic stopv);
      ser_rx = 1'b0;
      repeat (8) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         ser_rx = b[i];
         repeat (8) @(negedge clk);
      end
      ser_rx = stopv;
      repeat (8) @(negedge clk);
      ser_rx = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic catch_tx(output logic [7:0] b, output logic stopv);
      int guard = 0;
      while (ser_tx && guard < 400) begin
         @(negedge clk); guard++;
      end
      repeat (4) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         repeat (8) @(negedge clk);
         b[i] = ser_tx;
      end
      repeat (8) @(negedge clk);
      stopv = ser_tx;
   endtask

   task automatic wait_tx_idle();
      logic [7:0] s;
      for (int k = 0; k < 400; k++) begin
         rd(20, s);
         if (s[7]) break;
      end
   endtask

   initial begin
      logic [7:0] v, got;
      logic stp;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 irq", irq, 0);
      check("R1 txd", ser_tx, 1);
      rd(20, v); check("R1 status", v, 8'hA0);

      // R2 identification bytes and unmapped offsets
      for (int i = 0; i < 4; i++) begin
         rd(i * 4, v); check("R2 id", v, (IDV >> (8 * i)) & 8'hFF);
      end
      rd(2, v);  check("R2 unmapped", v, 0);
      rd(31, v); check("R2 unmapped", v, 0);

      // R3 divisor readback and bit time
      rd(24, v); check("R3 reset div lo", v, 1);
      wr(28, 8'hA5); rd(28, v); check("R3 div hi", v, 8'hA5);
      wr(28, 8'h00);
      wr(24, 8'h02); rd(24, v); check("R3 div lo", v, 2);
      wr(16, 8'h55);
      while (!ser_tx) @(negedge clk);
      n = 0;
      while (ser_tx && n < 100) begin @(negedge clk); n++; end
      check("R3 bit time div2", n, 12);
      wait_tx_idle();
      wr(24, 8'h01);

      // R4 transmit sweep
      foreach (IDV[i]) begin end
      for (int k = 0; k < 6; k++) begin
         logic [7:0] pat;
         pat = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'(37 * k + 11);
         wr(16, pat);
         rd(20, v); check("R4 tx busy flag", v[7], 0);
         catch_tx(got, stp);
         check("R4 tx char", got, pat);
         check("R4 tx stop", stp, 1);
         wait_tx_idle();
         rd(20, v); check("R4 tx empty again", v[7], 1);
      end

      // R5 write while busy ignored
      wr(16, 8'h3C);
      wr(16, 8'hC3);
      catch_tx(got, stp);
      check("R5 first char kept", got, 8'h3C);
      wait_tx_idle();
      n = 0;
      for (int k = 0; k < 120; k++) begin @(negedge clk); if (!ser_tx) n++; end
      check("R5 no second frame", n, 0);

      // R6 receive sweep over all byte values
      for (int b = 0; b < 256; b++) begin
         send_rx(8'(b), 1'b1);
         rd(16, v); check("R6 rx char", v, b);
      end
      rd(20, v); check("R6 empty after drain", v, 8'hA0);

      // R7 / R8 FIFO fill, flags, overrun
      send_rx(8'h11, 1); send_rx(8'h22, 1); send_rx(8'h33, 1);
      rd(20, v); check("R7 one free slot", v & 8'h38, 8'h10);
      send_rx(8'h44, 1);
      rd(20, v); check("R7 full", v & 8'h3A, 8'h08);
      send_rx(8'h55, 1);
      rd(20, v); check("R8 overrun set", v & 8'h3A, 8'h0A);
      rd(16, v); check("R7 order", v, 8'h11);
      rd(16, v); check("R8 kept", v, 8'h22);
      rd(16, v); check("R8 kept", v, 8'h33);
      rd(16, v); check("R8 kept", v, 8'h44);
      rd(20, v); check("R7 empty", v[5], 1);

      // R12 empty read returns last, FIFO unchanged
      rd(16, v); check("R12 last value", v, 8'h44);
      rd(20, v); check("R12 still empty", v[5], 1);
      send_rx(8'h9E, 1);
      rd(16, v); check("R12 pointers intact", v, 8'h9E);

      // R9 frame error
      send_rx(8'h6B, 0);
      rd(20, v); check("R9 frame error", v[0], 1);
      rd(16, v); check("R9 char stored", v, 8'h6B);

      // R10 sticky errors, enables, read-only bits
      wr(20, 8'h03);
      rd(20, v); check("R10 write 1 keeps", v, 8'hA3);
      wr(20, 8'h00);
      rd(20, v); check("R10 write 0 clears", v, 8'hA0);
      wr(20, 8'hFF);
      rd(20, v); check("R10 ro bits and enables", v, 8'hE4);
      wr(20, 8'h00);

      // R11 interrupt combining
      check("R11 idle irq", irq, 0);
      wr(20, 8'h04);
      check("R11 rx ie empty", irq, 0);
      send_rx(8'h5D, 1);
      check("R11 rx data", irq, 1);
      rd(16, v);
      @(negedge clk); check("R11 drained", irq, 0);
      wr(20, 8'h44);
      check("R11 tx empty", irq, 1);
      wr(16, 8'h81);
      check("R11 tx busy", irq, 0);
      wait_tx_idle();
      check("R11 tx done", irq, 1);
      wr(20, 8'h04);
      send_rx(8'h01, 0);
      rd(16, v);
      @(negedge clk); check("R11 error pending", irq, 1);
      wr(20, 8'h00);
      @(negedge clk); check("R11 cleared", irq, 0);

      // R13 glitch rejected
      ser_rx = 1'b0;
      repeat (2) @(negedge clk);
      ser_rx = 1'b1;
      repeat (120) @(negedge clk);
      rd(20, v); check("R13 glitch stores nothing", v, 8'hA0);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule